// File: doc/BRIEF.md
# Packed Column Predicate Scanner

This block is a streaming filter for one column of fixed-width unsigned values that are stored back to back, with no padding, inside 64-bit input words. A value may begin in one word and end in the next. The engine cuts each value out of the stream and tests it against a predicate in the same pass. For every value it produces a single match bit. The match bits are packed into 64-bit result words. The column is never written out in unpacked form. Only the compact match vector leaves the block.

A run starts with a one-cycle `start` pulse. The pulse captures the value width, the element count, the predicate mode and the operands. Input words then arrive on a valid/ready stream, and result words leave on a second valid/ready stream. The output side may apply back-pressure at any time. When it does, the engine holds its current result word and stops taking input until the word is accepted. No element is lost or produced twice. A transfer happens on a clock edge where both valid and ready are high. A source must keep its valid and data steady until that transfer. `done` pulses once when the run is complete.

Top module: `colscan_filter`

## Requirements
- R1: The value width W is between 1 and 32. Input word k carries stream bits 64k to 64k+63, with its bit 0 first. Element i takes stream bits i*W to i*W+W-1, with its least significant bit first, so an element may span two words.
- R2: In mode 0 (equality), the match bit is 1 exactly when the value equals operand A.
- R3: In mode 1 (range), the match bit is 1 exactly when A <= value <= B, with both comparisons unsigned.
- R4: In mode 2 (set), the match bit is 1 exactly when the value equals one of the 8 set entries whose enable bit is 1. Entry j uses bits 32j to 32j+31 of `cfg_set_vals` and enable bit j of `cfg_set_en`. An entry whose enable bit is 0 never causes a match.
- R5: In mode 3, every match bit is 0, and the run still produces all of its result words.
- R6: The match bit of element i is placed at bit i mod 64 of result word i/64. The last result word may be partly filled; its bits above the last element are 0. A run of N elements produces exactly ceil(N/64) result words.
- R7: A run consumes exactly ceil(N*W/64) input words. `in_ready` is low whenever no further word is needed, including while the block is idle.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` does not change. With any stall pattern on either stream, the result sequence is the same as with no stalls.
- R9: `done` is high for one cycle. It comes in the cycle after the final result word is transferred. For N = 0 it comes in the cycle after `start` is accepted, and no result word is produced.
- R10: `busy` goes high when a start with N > 0 is accepted and goes low when the final result word is transferred. A `start` pulse while `busy` is high is ignored and does not change the run in progress.
- R11: While reset is applied, `busy`, `done`, `in_ready` and `res_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when not busy; captures the configuration below |
| cfg_width | input | 6 | Value width W, from 1 to 32 |
| cfg_count | input | 16 | Element count N |
| cfg_mode | input | 2 | 0 equality, 1 range, 2 set membership, 3 no match |
| cfg_op_a | input | 32 | Equality operand, or lower bound of the range |
| cfg_op_b | input | 32 | Upper bound of the range |
| cfg_set_vals | input | 256 | Eight 32-bit set entries; entry j at bits 32j and up |
| cfg_set_en | input | 8 | Enable bit for each set entry |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Engine accepts an input word |
| in_data | input | 64 | Packed column data |
| res_valid | output | 1 | Result word is valid |
| res_ready | input | 1 | Consumer accepts the result word |
| res_data | output | 64 | Packed match bits |

## Verification
Some rules hold on every cycle, and assertions check them there. A stalled element or result word must stay valid and unchanged. Bits of the partly filled result word above its fill position must be zero. The unpack buffer must not overflow. The input side must stay closed while idle, and must never ask for words after all elements are consumed. `done` must never be high while busy.

Other behaviour can only be shown by the bench scenarios. These cover:
- the predicate results in every mode, including disabled set entries;
- bit placement for values that span two words;
- the exact input word count and the exact result word count;
- the cycle in which `done` appears;
- a second `start` that is ignored during a run;
- unchanged results under input gaps and output stalls.

// File: rtl/colscan_pkg.sv
package colscan_pkg;
  typedef enum logic [1:0] {
    PM_EQ    = 2'd0,
    PM_RANGE = 2'd1,
    PM_SET   = 2'd2,
    PM_OFF   = 2'd3
  } pred_mode_e;
endpackage

// File: rtl/colscan_unpack.sv
module colscan_unpack #(
  parameter int WORD_W = 64,
  parameter int VAL_W  = 32,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [$clog2(VAL_W+1)-1:0] load_width,
  input  logic [CNT_W-1:0]           load_count,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WORD_W-1:0]          in_data,
  output logic                       el_valid,
  input  logic                       el_ready,
  output logic [VAL_W-1:0]           el_value,
  output logic                       el_last
);
  localparam int WID_W  = $clog2(VAL_W+1);
  localparam int BUF_W  = 2*WORD_W;
  localparam int FILL_W = $clog2(BUF_W+1);
  localparam int TOT_W  = CNT_W + WID_W + 1;
  localparam int SH     = $clog2(WORD_W);

  logic [BUF_W-1:0]  bits_q, bits_pop, bits_nxt;
  logic [FILL_W-1:0] fill_q, fill_pop, fill_nxt;
  logic [TOT_W-1:0]  words_q, tot_bits;
  logic [CNT_W-1:0]  elems_q;
  logic [WID_W-1:0]  width_q;
  logic [VAL_W-1:0]  vmask;
  logic              push, pop;

  // stream bits needed for the run, rounded up to whole words
  assign tot_bits = TOT_W'(load_count) * TOT_W'(load_width) + TOT_W'(WORD_W-1);

  assign in_ready = (words_q != '0) && (fill_q <= FILL_W'(WORD_W));
  assign el_valid = (elems_q != '0) && (fill_q >= FILL_W'(width_q));
  assign el_last  = (elems_q == CNT_W'(1));
  assign push     = in_valid && in_ready;
  assign pop      = el_valid && el_ready;

  assign vmask    = (width_q >= WID_W'(VAL_W)) ? '1 : ~({VAL_W{1'b1}} << width_q);
  assign el_value = bits_q[VAL_W-1:0] & vmask;

  always_comb begin
    bits_pop = pop ? (bits_q >> width_q) : bits_q;
    fill_pop = pop ? (fill_q - FILL_W'(width_q)) : fill_q;
    bits_nxt = bits_pop;
    fill_nxt = fill_pop;
    if (push) begin
      bits_nxt = bits_pop | ({{WORD_W{1'b0}}, in_data} << fill_pop);
      fill_nxt = fill_pop + FILL_W'(WORD_W);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q  <= '0;
      fill_q  <= '0;
      words_q <= '0;
      elems_q <= '0;
      width_q <= '0;
    end else if (load) begin
      bits_q  <= '0;
      fill_q  <= '0;
      words_q <= TOT_W'(tot_bits >> SH);
      elems_q <= load_count;
      width_q <= load_width;
    end else begin
      bits_q <= bits_nxt;
      fill_q <= fill_nxt;
      if (push) words_q <= words_q - TOT_W'(1);
      if (pop)  elems_q <= elems_q - CNT_W'(1);
    end
  end

  // R8: an element stalled by the packer stays offered and unchanged
  a_r8_elem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && !el_ready |=> el_valid && $stable(el_value));

  // R1: the two-word shift buffer never overflows
  a_r1_fill_room: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(BUF_W));

  // R7: no input word is requested once every element has been taken
  a_r7_words_need_elems: assert property (@(posedge clk) disable iff (!rst_n)
    words_q != '0 |-> elems_q != '0);
endmodule

// File: rtl/colscan_pred.sv
module colscan_pred
  import colscan_pkg::*;
#(
  parameter int VAL_W = 32,
  parameter int SET_N = 8
) (
  input  pred_mode_e             mode,
  input  logic [VAL_W-1:0]       value,
  input  logic [VAL_W-1:0]       op_a,
  input  logic [VAL_W-1:0]       op_b,
  input  logic [SET_N*VAL_W-1:0] set_vals,
  input  logic [SET_N-1:0]       set_en,
  output logic                   hit
);
  logic [SET_N-1:0] set_hit;

  for (genvar g = 0; g < SET_N; g++) begin : g_set
    assign set_hit[g] = set_en[g] && (set_vals[g*VAL_W +: VAL_W] == value);
  end

  always_comb begin
    unique case (mode)
      PM_EQ:    hit = (value == op_a);
      PM_RANGE: hit = (value >= op_a) && (value <= op_b);
      PM_SET:   hit = |set_hit;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/colscan_pack.sv
module colscan_pack #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_val,
  input  logic              bit_last,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data,
  output logic              final_hs
);
  localparam int POS_W = $clog2(WORD_W);

  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic [POS_W-1:0]  pos_q;
  logic              last_q, flush, out_free, take;

  assign flush     = (pos_q == POS_W'(WORD_W-1)) || bit_last;
  assign out_free  = !res_valid || res_ready;
  assign bit_ready = !flush || out_free;
  assign take      = bit_valid && bit_ready;
  assign acc_nxt   = acc_q | (WORD_W'(bit_val) << pos_q);
  assign final_hs  = res_valid && res_ready && last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      pos_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      last_q    <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (take) begin
        if (flush) begin
          res_data  <= acc_nxt;
          res_valid <= 1'b1;
          last_q    <= bit_last;
          acc_q     <= '0;
          pos_q     <= '0;
        end else begin
          acc_q <= acc_nxt;
          pos_q <= pos_q + POS_W'(1);
        end
      end
    end
  end

  // R8: a result word is held steady until the consumer takes it
  a_r8_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R6: bits not yet filled in the word under assembly remain zero
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q >> pos_q) == '0);
endmodule

// File: rtl/colscan_filter.sv
module colscan_filter
  import colscan_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int VAL_W  = 32,
  parameter int CNT_W  = 16,
  parameter int SET_N  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(VAL_W+1)-1:0] cfg_width,
  input  logic [CNT_W-1:0]           cfg_count,
  input  logic [1:0]                 cfg_mode,
  input  logic [VAL_W-1:0]           cfg_op_a,
  input  logic [VAL_W-1:0]           cfg_op_b,
  input  logic [SET_N*VAL_W-1:0]     cfg_set_vals,
  input  logic [SET_N-1:0]           cfg_set_en,
  output logic                       busy,
  output logic                       done,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WORD_W-1:0]          in_data,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [WORD_W-1:0]          res_data
);
  logic                   start_ok, busy_q, done_q, final_hs;
  pred_mode_e             mode_q;
  logic [VAL_W-1:0]       op_a_q, op_b_q;
  logic [SET_N*VAL_W-1:0] set_q;
  logic [SET_N-1:0]       en_q;
  logic                   el_valid, el_ready, el_last, hit;
  logic [VAL_W-1:0]       el_value;

  assign start_ok = start && !busy_q;
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= PM_OFF;
      op_a_q <= '0;
      op_b_q <= '0;
      set_q  <= '0;
      en_q   <= '0;
    end else begin
      done_q <= final_hs || (start_ok && cfg_count == '0);
      if (start_ok) begin
        busy_q <= (cfg_count != '0);
        mode_q <= pred_mode_e'(cfg_mode);
        op_a_q <= cfg_op_a;
        op_b_q <= cfg_op_b;
        set_q  <= cfg_set_vals;
        en_q   <= cfg_set_en;
      end else if (final_hs) begin
        busy_q <= 1'b0;
      end
    end
  end

  colscan_unpack #(.WORD_W(WORD_W), .VAL_W(VAL_W), .CNT_W(CNT_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load(start_ok),
    .load_width(cfg_width), .load_count(cfg_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .el_valid(el_valid), .el_ready(el_ready), .el_value(el_value), .el_last(el_last)
  );

  colscan_pred #(.VAL_W(VAL_W), .SET_N(SET_N)) u_pred (
    .mode(mode_q), .value(el_value), .op_a(op_a_q), .op_b(op_b_q),
    .set_vals(set_q), .set_en(en_q), .hit(hit)
  );

  colscan_pack #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .bit_valid(el_valid), .bit_ready(el_ready), .bit_val(hit), .bit_last(el_last),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .final_hs(final_hs)
  );

  // R7: the input side is closed whenever no run is in progress
  a_r7_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !in_ready);

  // R9: completion is only signalled once the run has ended
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: tb/sim_colscan_filter.sv
module sim_colscan_filter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [5:0]   cfg_width = '0;
  logic [15:0]  cfg_count = '0;
  logic [1:0]   cfg_mode = '0;
  logic [31:0]  cfg_op_a = '0, cfg_op_b = '0;
  logic [255:0] cfg_set_vals = '0;
  logic [7:0]   cfg_set_en = '0;
  logic         busy, done, in_ready, res_valid;
  logic         in_valid = 1'b0;
  logic         res_ready = 1'b1;
  logic [63:0]  in_data = '0;
  logic [63:0]  res_data;

  int checks = 0, failures = 0, cyc = 0;
  int done_cnt = 0, done_cyc = 0, last_cyc = 0;
  logic [63:0] exp_q[$];
  logic [63:0] words[0:63];

  always #10 clk = ~clk;

  colscan_filter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode), .cfg_op_a(cfg_op_a),
    .cfg_op_b(cfg_op_b), .cfg_set_vals(cfg_set_vals), .cfg_set_en(cfg_set_en),
    .busy(busy), .done(done), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] vmask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] gen(input int i, input int seed, input int w);
    logic [31:0] x;
    x = (i * 32'h9E37_79B1) ^ (seed * 32'h85EB_CA6B);
    x = x ^ (x >> 15);
    return x & vmask(w);
  endfunction

  function automatic logic [255:0] mkset(input int seed, input int w);
    logic [255:0] s;
    for (int k = 0; k < 8; k++) s[k*32 +: 32] = gen(k*5 + 1, seed, w);
    return s;
  endfunction

  function automatic bit model(input logic [31:0] v, input logic [1:0] m, input logic [31:0] a,
                               input logic [31:0] b, input logic [255:0] sv, input logic [7:0] en);
    bit r;
    r = 1'b0;
    case (m)
      2'd0: r = (v == a);
      2'd1: r = (v >= a) && (v <= b);
      2'd2: for (int k = 0; k < 8; k++) if (en[k] && sv[k*32 +: 32] == v) r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // scoreboard monitor: samples transfers away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected result word", res_data, '0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(res_data === e, "R2/R3/R4/R5/R6 result word", res_data, e);
          if (exp_q.size() == 0) last_cyc = cyc;
        end
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_case(input int w, input int n, input logic [1:0] m, input logic [31:0] a,
                          input logic [31:0] b, input logic [255:0] sv, input logic [7:0] en,
                          input int gap, input int stall, input int seed, input bit restart,
                          input string tag);
    int nw, idx, extra, ref_cyc, it;
    logic [63:0] ew;
    nw = (n*w + 63) / 64;
    for (int i = 0; i < 64; i++) words[i] = '0;
    ew = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] v;
      v = gen(i, seed, w);
      for (int k = 0; k < w; k++) words[(i*w + k) / 64][(i*w + k) % 64] = v[k];
      ew[i % 64] = model(v, m, a, b, sv, en);
      if ((i % 64) == 63 || i == n - 1) begin
        exp_q.push_back(ew);
        ew = '0;
      end
    end
    done_cnt = 0;
    last_cyc = -10;
    @(posedge clk); #1;
    start = 1'b1; cfg_width = 6'(w); cfg_count = 16'(n); cfg_mode = m;
    cfg_op_a = a; cfg_op_b = b; cfg_set_vals = sv; cfg_set_en = en;
    @(negedge clk);
    ref_cyc = cyc;
    idx = 0; extra = 0; it = 0;
    while (done_cnt == 0 && it < 20000) begin
      @(posedge clk); #1;
      // R10: a second start during the run, with a different mode, must be ignored
      start = restart && (it == 5);
      cfg_mode = (restart && it == 5) ? 2'd3 : m;
      in_valid = !(gap != 0 && (it % 4) == 1);
      in_data = (idx < nw) ? words[idx] : 64'hDEAD_BEEF_F00D_CAFE;
      res_ready = (stall == 0) ? 1'b1 : (stall == 1) ? ((it % 3) != 0) : ((it % 5) == 0);
      @(negedge clk);
      if (in_valid && in_ready) begin
        if (idx < nw) idx++;
        else extra++;
      end
      it++;
    end
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      start = 1'b0;
      res_ready = 1'b1;
      @(negedge clk);
      if (in_valid && in_ready) extra++;
    end
    in_valid = 1'b0;
    chk(it < 20000, {"R9 run finishes ", tag}, 64'(it), 64'(20000));
    chk(exp_q.size() == 0, {"R6 all result words delivered ", tag}, 64'(exp_q.size()), 0);
    chk(idx == nw && extra == 0, {"R7 input words consumed ", tag}, 64'(idx + extra), 64'(nw));
    chk(done_cnt == 1, {"R9 single done pulse ", tag}, 64'(done_cnt), 1);
    chk(done_cyc == ((n == 0) ? ref_cyc : last_cyc) + 1, {"R9 done timing ", tag},
        64'(done_cyc), 64'(((n == 0) ? ref_cyc : last_cyc) + 1));
    chk(!busy && !in_ready, {"R10 idle after run ", tag}, {62'd0, busy, in_ready}, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !in_ready && !res_valid, "R11 reset outputs",
        {60'd0, busy, done, in_ready, res_valid}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready && !busy, "R7 closed when idle", {62'd0, in_ready, busy}, 0);

    // R1/R2: 13-bit values spanning words, equality
    run_case(13, 150, 2'd0, gen(7, 1, 13), 0, '0, '0, 0, 0, 1, 1'b0, "eq13");
    // R3/R8/R10: full 32-bit range, gaps, stalls, ignored restart
    run_case(32, 70, 2'd1, 32'h4000_0000, 32'hC000_0000, '0, '0, 1, 1, 2, 1'b1, "range32");
    // R1/R6: single-bit values, exactly one full result word
    run_case(1, 64, 2'd0, 32'd1, 0, '0, '0, 0, 0, 3, 1'b0, "eq1");
    // R4/R8: set membership with some entries disabled, heavy back-pressure
    run_case(7, 200, 2'd2, 0, 0, mkset(4, 7), 8'b1011_0110, 1, 2, 4, 1'b0, "set7");
    // R3: degenerate range lo == hi
    run_case(20, 5, 2'd1, gen(2, 5, 20), gen(2, 5, 20), '0, '0, 0, 1, 5, 1'b0, "range20");
    // R9: empty run
    run_case(8, 0, 2'd0, 0, 0, '0, '0, 0, 0, 6, 1'b0, "empty");
    // R5: mode 3 never matches
    run_case(5, 10, 2'd3, gen(1, 6, 5), 32'hFFFF_FFFF, mkset(6, 5), 8'hFF, 0, 0, 6, 1'b0, "off");
    // R4/R6: one trailing element in a padded final word, two entries enabled
    run_case(3, 65, 2'd2, 0, 0, mkset(7, 3), 8'b0000_0011, 1, 1, 7, 1'b0, "set3");
    // R2: full-width equality
    run_case(32, 3, 2'd0, gen(1, 8, 32), 0, '0, '0, 0, 2, 8, 1'b0, "eq32");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule